// File: doc/BRIEF.md
# Display-Off Blanking Controller

This block turns an active-low display-off request into a blanking control for the common drive stage and an active-low status flag for neighbouring drivers. While blanking is high, the drive stage parks every row output at its non-select level. A static mode input picks one of two release behaviours.

In immediate mode, blanking follows the request directly. In delayed mode, raising the request does not end blanking at once. The block first counts a fixed number of frame-start tokens, sixteen by default. A token is a high level on the serial scan input that is currently active, and that input is chosen by the scan-direction select. Blanking drops on the clock edge that samples the final token. A new request clears the count without waiting for a clock edge. Power-up reset leaves the block blanked.

Top module: `blank_release_ctrl`

## Requirements
- R1: While `rstN` is low, `blank` is 1 and `offStatN` is 0.
- R2: While `offReqN` is low, `blank` is 1 in both modes. This takes effect without any clock edge.
- R3: With `delayMode` = 0, `blank` equals the inverse of `offReqN` at all times after reset.
- R4: With `delayMode` = 1, `blank` stays 1 after `offReqN` rises until 16 tokens have been sampled. It falls to 0 on the rising `clk` edge that samples the 16th token, and 15 tokens are not enough.
- R5: A token is a 1 on the active serial input at a rising `clk` edge. `scanDir` = 0 selects `serA` and `scanDir` = 1 selects `serB`. The other input has no effect on the count.
- R6: Once the count has reached 16, further tokens change nothing: `blank` stays 0 until the next request.
- R7: Any low level on `offReqN` discards tokens counted so far. Tokens seen while the request is low are not counted, so every release needs a full 16 new tokens.
- R8: `offStatN` is always the inverse of `blank`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock; tokens are sampled on its rising edge |
| rstN | input | 1 | Active-low power-up reset, asynchronous |
| offReqN | input | 1 | Active-low display-off request, asynchronous |
| delayMode | input | 1 | 0 = immediate release, 1 = release after the frame count |
| scanDir | input | 1 | Selects the active serial input (0 = serA, 1 = serB) |
| serA | input | 1 | Serial scan input A, used as the token source when scanDir = 0 |
| serB | input | 1 | Serial scan input B, used as the token source when scanDir = 1 |
| blank | output | 1 | 1 forces every drive output to the non-select level |
| offStatN | output | 1 | Active-low display-off status |

## Verification
The clocked properties assume that every low pulse on `offReqN` covers at least one rising clock edge. The request also works asynchronously, so a shorter pulse would clear the counter between edges, where the properties cannot see it. They also assume that `delayMode` and `scanDir` change only while the request is held low, because both are treated as static straps. The stimulus drives every input two nanoseconds after a rising edge and holds each request pulse low for several cycles. It switches mode and direction only inside such a pulse, and it checks the asynchronous path by reading the outputs one nanosecond after the request falls.

// File: rtl/blank_rel_pkg.sv
package blank_rel_pkg;

  // Strobes from the control unit to the counting datapath
  typedef struct packed {
    logic clrN;  // asynchronous clear of the frame counter, active low
    logic inc;   // count one token on this edge
  } relStrobe_t;

endpackage

// File: rtl/blank_rel_datapath.sv
module blank_rel_datapath
  import blank_rel_pkg::*;
#(
  parameter int FRAME_COUNT = 16,
  parameter int SER_PORTS   = 2
) (
  input  logic                 clk,
  input  relStrobe_t           stb,
  input  logic                 scanDir,
  input  logic [SER_PORTS-1:0] serIn,
  output logic                 tokenBit,
  output logic                 countDone
);

  localparam int CNT_W = $clog2(FRAME_COUNT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_COUNT);
  localparam int SEL_W = (SER_PORTS > 1) ? $clog2(SER_PORTS) : 1;

  logic             clrN;
  logic [CNT_W-1:0] count;
  logic [SEL_W-1:0] serSel;

  assign clrN   = stb.clrN;
  assign serSel = SEL_W'(scanDir);

  // Token source: the serial input picked by the scan direction
  generate
    if (SER_PORTS > 1) begin : g_mux
      assign tokenBit = serIn[serSel];
    end else begin : g_single
      assign tokenBit = serIn[0];
    end
  endgenerate

  // Saturating frame counter with asynchronous clear
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      count <= '0;
    end else if (stb.inc) begin
      count <= count + 1'b1;
    end
  end

  assign countDone = (count == CNT_LAST);

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!clrN)
    count <= CNT_LAST);  // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clrN)
    stb.inc |=> count == CNT_W'($past(count) + 1'b1));  // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!clrN)
    !stb.inc |=> $stable(count));  // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!clrN)
    countDone |=> countDone);  // R6

endmodule

// File: rtl/blank_rel_control.sv
module blank_rel_control
  import blank_rel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       offReqN,
  input  logic       delayMode,
  input  logic       tokenBit,
  input  logic       countDone,
  output relStrobe_t stb,
  output logic       blank,
  output logic       offStatN
);

  logic holdRelease;

  // Counter is held clear while reset or a request is active
  assign stb.clrN = rstN & offReqN;
  assign stb.inc  = tokenBit & ~countDone;

  // In delayed mode blanking persists until the frame count completes
  assign holdRelease = delayMode & ~countDone;
  assign blank       = ~rstN | ~offReqN | holdRelease;
  assign offStatN    = ~blank;

  AST_RESET_BLANKS: assert property (@(posedge clk)
    !rstN |-> blank && !offStatN);  // R1
  AST_REQ_BLANKS: assert property (@(posedge clk) disable iff (!rstN)
    !offReqN |-> blank && !offStatN);  // R2
  AST_IMMEDIATE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    !delayMode |-> (blank == !offReqN));  // R3
  AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (delayMode && !countDone) |-> blank);  // R4
  AST_STATUS_INVERSE: assert property (@(posedge clk)
    offStatN != blank);  // R8

endmodule

// File: rtl/blank_release_ctrl.sv
module blank_release_ctrl
  import blank_rel_pkg::*;
#(
  parameter int FRAME_COUNT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic offReqN,
  input  logic delayMode,
  input  logic scanDir,
  input  logic serA,
  input  logic serB,
  output logic blank,
  output logic offStatN
);

  relStrobe_t stb;
  logic       tokenBit;
  logic       countDone;

  blank_rel_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .offReqN   (offReqN),
    .delayMode (delayMode),
    .tokenBit  (tokenBit),
    .countDone (countDone),
    .stb       (stb),
    .blank     (blank),
    .offStatN  (offStatN)
  );

  blank_rel_datapath #(
    .FRAME_COUNT (FRAME_COUNT),
    .SER_PORTS   (2)
  ) i_datapath (
    .clk       (clk),
    .stb       (stb),
    .scanDir   (scanDir),
    .serIn     ({serB, serA}),
    .tokenBit  (tokenBit),
    .countDone (countDone)
  );

endmodule

// File: tb/test_blank_release_ctrl.sv
module test_blank_release_ctrl;

  logic clk = 1'b0;
  logic rstN, offReqN, delayMode, scanDir, serA, serB;
  logic blank, offStatN;

  int checks = 0;
  int errors = 0;
  int refCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  blank_release_ctrl i_blank_release_ctrl (
    .clk(clk), .rstN(rstN), .offReqN(offReqN), .delayMode(delayMode),
    .scanDir(scanDir), .serA(serA), .serB(serB),
    .blank(blank), .offStatN(offStatN)
  );

  // Behavioural reference: number of frame tokens seen since release
  always @(posedge clk) begin
    if (!rstN || !offReqN) refCount = 0;
    else if ((scanDir ? serB : serA) && refCount < 16) refCount = refCount + 1;
  end

  function automatic logic expBlank();
    return !rstN || !offReqN || (delayMode && refCount < 16);
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // Compare with the reference model on every cycle
  always @(negedge clk) begin
    if (!finished) begin
      string tag;
      if (!rstN) tag = "R1";
      else if (!offReqN) tag = "R2";
      else if (!delayMode) tag = "R3";
      else tag = "R4";
      check(blank, expBlank(), tag);
      check(offStatN, !expBlank(), "R8");
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // Drive n tokens on one input (0 = serA, 1 = serB); sampled on the n edges after
  task automatic tokens(input int n, input bit onB);
    repeat (n) begin
      @(posedge clk); #2;
      if (onB) serB = 1'b1; else serA = 1'b1;
    end
    @(posedge clk); #2;
    serA = 1'b0; serB = 1'b0;
  endtask

  task automatic finish();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got=running exp=done");
      finish();
    end
  end

  initial begin
    rstN = 0; offReqN = 0; delayMode = 1; scanDir = 0; serA = 0; serB = 0;
    step(3);
    @(negedge clk);
    check(blank, 1'b1, "R1 reset blank");
    check(offStatN, 1'b0, "R1 reset status");
    step(1); rstN = 1;
    step(3); offReqN = 1;
    // Inactive input (serB while scanDir=0) must not count
    tokens(20, 1'b1);
    @(negedge clk);
    check(blank, 1'b1, "R5 inactive input ignored");
    tokens(15, 1'b0);
    @(negedge clk);
    check(blank, 1'b1, "R4 held after 15 tokens");
    tokens(1, 1'b0);
    @(negedge clk);
    check(blank, 1'b0, "R4 released on 16th token");
    check(offStatN, 1'b1, "R8 status high when released");
    tokens(10, 1'b0);
    @(negedge clk);
    check(blank, 1'b0, "R6 saturated count stays released");
    // Asynchronous assertion of blanking
    @(posedge clk); #2; offReqN = 0; #1;
    check(blank, 1'b1, "R2 async blank");
    check(offStatN, 1'b0, "R2 async status");
    tokens(20, 1'b0);
    #1; offReqN = 1;
    @(negedge clk);
    check(blank, 1'b1, "R7 tokens while low discarded");
    // Switch direction inside a request pulse
    step(1); offReqN = 0; step(2); scanDir = 1; step(2); offReqN = 1;
    tokens(5, 1'b0);
    @(negedge clk);
    check(blank, 1'b1, "R5 serA ignored when scanDir=1");
    tokens(16, 1'b1);
    @(negedge clk);
    check(blank, 1'b0, "R5 serB tokens release");
    // Partial count discarded by a new request
    step(1); offReqN = 0; step(3); offReqN = 1;
    tokens(10, 1'b1);
    step(1); offReqN = 0; step(3); offReqN = 1;
    tokens(10, 1'b1);
    @(negedge clk);
    check(blank, 1'b1, "R7 restart needs full count");
    tokens(6, 1'b1);
    @(negedge clk);
    check(blank, 1'b0, "R7 released after fresh 16");
    // Immediate mode
    step(1); offReqN = 0; step(2); delayMode = 0; step(2);
    offReqN = 1; #1;
    check(blank, 1'b0, "R3 immediate release");
    check(offStatN, 1'b1, "R3 status follows request");
    for (int i = 0; i < 4; i++) begin
      step(2); offReqN = 0; #1;
      check(blank, 1'b1, "R3 request low blanks");
      step(3); offReqN = 1; #1;
      check(blank, 1'b0, "R3 request high releases");
    end
    step(4);
    finish();
  end

endmodule